// File: doc/BRIEF.md
# Parallel Port Channel Receiver

This block is one receive channel of a source-synchronous parallel port. The far-end transmitter drives a clock, a data bus and two framing strobes. A data strobe says whether the word on the bus is live. A line strobe marks the first word of a line. The receiver samples the bus on one clock edge or on both, and discards words for which the data strobe is low. It hands the captured words, each with a start-of-line flag, to a valid/ready stream in the system clock domain. The words cross between the two clocks through a small asynchronous FIFO.

Three quasi-static controls set the capture. One picks single-edge or dual-edge capture. One picks which edge is used in single-edge mode. One sets the word width from 8 to 16 bits. They are changed only while the link is idle and the FIFO is empty.

The block drives a hold-off output back to the transmitter when the FIFO runs short of space. The transmitter then pauses. In dual-edge mode the external clock must run at no more than one eighth of the system clock.

On the output stream a word is transferred on any system clock edge where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, the word on the output stays put. Stalling the stream lets the FIFO fill, which raises `pin_wait`. Words that arrive when the FIFO is completely full are discarded.

Top module: `ppr_rx`

## Requirements
- R1: With `cfg_ddr`=0 and `cfg_clk_inv`=0, one word is taken from the bus on each rising edge of `io_clk`, and the falling edge is ignored.
- R2: With `cfg_ddr`=0 and `cfg_clk_inv`=1, one word is taken on each falling edge of `io_clk`, and the rising edge is ignored.
- R3: With `cfg_ddr`=1, a word is taken on both edges of `io_clk`, and `cfg_clk_inv` has no effect.
- R4: A word sampled while `pin_enable` is low never appears on the output stream.
- R5: `m_sol` is 1 for a word exactly when `pin_start` was high on the edge that captured it.
- R6: `m_data` bits at or above the configured width read 0. A `cfg_width` below 8 acts as 8, and one above DW acts as DW.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` and `m_sol` hold their values.
- R8: `pin_wait` goes high once the number of free FIFO entries is below WAIT_LVL. It goes low again once the number of free entries is at least WAIT_LVL.
- R9: The FIFO never holds more than 2^AW entries. Words that arrive while it is full are dropped, and the words already stored are delivered intact.
- R10: After reset, `m_valid` and `pin_wait` are 0.
- R11: Words leave in arrival order. In dual-edge mode, the rising-edge word of a clock period comes before the falling-edge word of the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock (output stream domain) |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| io_clk | input | 1 | Clock from the external transmitter |
| pin_data | input | DW | Parallel data bus |
| pin_start | input | 1 | First-word-of-line strobe |
| pin_enable | input | 1 | Word-valid strobe |
| pin_wait | output | 1 | Hold-off request to the transmitter (io_clk domain) |
| cfg_ddr | input | 1 | 1: capture on both edges |
| cfg_clk_inv | input | 1 | Single-edge mode: 1 selects the falling edge |
| cfg_width | input | $clog2(DW+1) | Word width in bits |
| m_valid | output | 1 | Output word available |
| m_ready | input | 1 | Consumer accepts the word |
| m_data | output | DW | Output word, masked to width |
| m_sol | output | 1 | Output word starts a line |

## Verification
The hardest state to reach is a full FIFO with `pin_wait` high while the transmitter still sends words. Reaching it also requires showing that the threshold is not crossed too early and that the surplus words are lost while the stored ones survive. The stimulus holds `m_ready` low and pushes words in steps. It checks `pin_wait` at fill levels just under and at the threshold. It then overruns the FIFO by two words, releases the stream and expects exactly the first eight words back. Dual-edge pairs whose halves have mixed data-strobe values cover the case where only one half of a stored pair is live.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

  typedef enum logic [1:0] {
    CAP_RISE = 2'd0,
    CAP_FALL = 2'd1,
    CAP_BOTH = 2'd2
  } ppr_cap_e;

  function automatic ppr_cap_e ppr_mode(input logic ddr, input logic inv);
    if (ddr) return CAP_BOTH;
    if (inv) return CAP_FALL;
    return CAP_RISE;
  endfunction

endpackage

// File: rtl/ppr_capture.sv
// io_clk domain: samples the pins on both edges and packs one FIFO entry
// per io_clk period as {hi half, lo half}; each half is {live, sol, data}.
module ppr_capture #(
  parameter int DW = 16,
  parameter int WW = 5,
  localparam int HW = DW + 2,
  localparam int EW = 2 * HW
) (
  input  logic          io_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_data,
  input  logic          pin_start,
  input  logic          pin_enable,
  input  logic          cfg_ddr,
  input  logic          cfg_clk_inv,
  input  logic [WW-1:0] cfg_width,
  output logic          wr_req,
  output logic [EW-1:0] wr_entry
);
  import ppr_pkg::*;

  logic [DW-1:0] mask;
  logic [HW-1:0] word_in, rise_q, fall_q, lo_half, hi_half;
  ppr_cap_e      mode;
  int            wlim;

  always_comb begin
    wlim = int'(cfg_width);
    if (wlim < 8)  wlim = 8;
    if (wlim > DW) wlim = DW;
    for (int i = 0; i < DW; i++) mask[i] = (i < wlim);
  end

  assign word_in = {pin_enable, pin_start, pin_data & mask};

  always_ff @(posedge io_clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= word_in;
  end

  always_ff @(negedge io_clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= word_in;
  end

  assign mode = ppr_mode(cfg_ddr, cfg_clk_inv);

  always_comb begin
    unique case (mode)
      CAP_BOTH: begin lo_half = rise_q; hi_half = fall_q; end
      CAP_FALL: begin lo_half = fall_q; hi_half = '0;     end
      default:  begin lo_half = rise_q; hi_half = '0;     end
    endcase
  end

  assign wr_req   = lo_half[HW-1] | hi_half[HW-1];
  assign wr_entry = {hi_half, lo_half};
endmodule

// File: rtl/ppr_afifo.sv
module ppr_afifo #(
  parameter int EW = 36,
  parameter int AW = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [EW-1:0] wr_data,
  output logic [AW:0]   wr_fill,
  input  logic          rd_pop,
  output logic [EW-1:0] rd_data,
  output logic          rd_empty
);
  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   rgray_s1, rgray_s2, rbin_w;
  logic [AW:0]   wgray_s1, wgray_s2;
  logic          wr_ok;

  // write side
  always_comb begin
    rbin_w[AW] = rgray_s2[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_w[i] = rbin_w[i+1] ^ rgray_s2[i];
  end

  assign wr_fill = wbin - rbin_w;
  assign wr_ok   = wr_req && (wr_fill != FULL_CNT);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rgray_s1 <= '0;
      rgray_s2 <= '0;
    end else begin
      rgray_s1 <= rgray;
      rgray_s2 <= rgray_s1;
      if (wr_ok) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read side
  assign rd_empty = (rgray == wgray_s2);
  assign rd_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wgray_s1 <= '0;
      wgray_s2 <= '0;
    end else begin
      wgray_s1 <= wgray;
      wgray_s2 <= wgray_s1;
      if (rd_pop && !rd_empty) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
    end
  end
endmodule

// File: rtl/ppr_unpack.sv
// sys_clk domain: presents the live halves of the head entry one at a time,
// low half first, and pops the entry after its last live half.
module ppr_unpack #(
  parameter int DW = 16,
  localparam int HW = DW + 2,
  localparam int EW = 2 * HW
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic [EW-1:0] entry,
  input  logic          empty,
  output logic          pop,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_sol
);
  logic [HW-1:0] lo_half, hi_half, cur;
  logic          half_q, sel_hi, last, xfer;

  assign lo_half = entry[HW-1:0];
  assign hi_half = entry[EW-1:HW];
  assign sel_hi  = half_q | ~lo_half[HW-1];
  assign cur     = sel_hi ? hi_half : lo_half;
  assign last    = sel_hi | ~hi_half[HW-1];
  assign m_valid = !empty && cur[HW-1];
  assign m_sol   = cur[HW-2];
  assign m_data  = cur[DW-1:0];
  assign xfer    = m_valid && m_ready;
  assign pop     = xfer && last;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n)    half_q <= 1'b0;
    else if (xfer) half_q <= ~last;
  end
endmodule

// File: rtl/ppr_rx.sv
module ppr_rx #(
  parameter int DW       = 16,
  parameter int AW       = 3,
  parameter int WAIT_LVL = 3,
  localparam int WW = $clog2(DW + 1)
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic          io_clk,
  input  logic [DW-1:0] pin_data,
  input  logic          pin_start,
  input  logic          pin_enable,
  output logic          pin_wait,
  input  logic          cfg_ddr,
  input  logic          cfg_clk_inv,
  input  logic [WW-1:0] cfg_width,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_sol
);
  localparam int EW = 2 * (DW + 2);
  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] WLV = (AW + 1)'(WAIT_LVL);

  logic          wr_req, rd_pop, rd_empty;
  logic [EW-1:0] wr_entry, rd_entry;
  logic [AW:0]   wr_fill, free_cnt;

  ppr_capture #(.DW(DW), .WW(WW)) u_cap (
    .io_clk(io_clk), .rst_n(rst_n),
    .pin_data(pin_data), .pin_start(pin_start), .pin_enable(pin_enable),
    .cfg_ddr(cfg_ddr), .cfg_clk_inv(cfg_clk_inv), .cfg_width(cfg_width),
    .wr_req(wr_req), .wr_entry(wr_entry)
  );

  ppr_afifo #(.EW(EW), .AW(AW)) u_fifo (
    .wclk(io_clk), .rclk(sys_clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_data(wr_entry), .wr_fill(wr_fill),
    .rd_pop(rd_pop), .rd_data(rd_entry), .rd_empty(rd_empty)
  );

  ppr_unpack #(.DW(DW)) u_out (
    .sys_clk(sys_clk), .rst_n(rst_n),
    .entry(rd_entry), .empty(rd_empty), .pop(rd_pop),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sol(m_sol)
  );

  assign free_cnt = FULL_CNT - wr_fill;

  always_ff @(posedge io_clk or negedge rst_n) begin
    if (!rst_n) pin_wait <= 1'b0;
    else        pin_wait <= (free_cnt < WLV);
  end
endmodule

// File: rtl/ppr_rx_chk.sv
module ppr_rx_chk #(
  parameter int DW       = 16,
  parameter int AW       = 3,
  parameter int WAIT_LVL = 3,
  parameter int WW       = 5
) (
  input logic          sys_clk,
  input logic          io_clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data,
  input logic          m_sol,
  input logic [WW-1:0] cfg_width,
  input logic          pin_wait,
  input logic [AW:0]   wr_fill
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] hi_bits;
  always_comb begin
    int w;
    w = int'(cfg_width);
    if (w < 8)  w = 8;
    if (w > DW) w = DW;
    for (int i = 0; i < DW; i++) hi_bits[i] = (i >= w);
  end

  p_hold_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sol));

  p_mask_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    m_valid |-> (m_data & hi_bits) == '0);

  p_no_overflow_r9: assert property (@(posedge io_clk) disable iff (!rst_n)
    int'(wr_fill) <= DEPTH);

  p_wait_rise_r8: assert property (@(posedge io_clk) disable iff (!rst_n)
    $rose(pin_wait) |-> int'($past(wr_fill)) > DEPTH - WAIT_LVL);

  p_wait_fall_r8: assert property (@(posedge io_clk) disable iff (!rst_n)
    $fell(pin_wait) |-> int'($past(wr_fill)) <= DEPTH - WAIT_LVL);
endmodule

bind ppr_rx ppr_rx_chk #(.DW(DW), .AW(AW), .WAIT_LVL(WAIT_LVL), .WW(WW)) u_chk (
  .sys_clk(sys_clk), .io_clk(io_clk), .rst_n(rst_n),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sol(m_sol),
  .cfg_width(cfg_width), .pin_wait(pin_wait), .wr_fill(wr_fill)
);

// File: tb/ppr_rx_test.sv
`timescale 1ns/1ps
module ppr_rx_test;
  logic        sys_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_clk = 1'b0;
  logic [15:0] pin_data = '0;
  logic        pin_start = 1'b0, pin_enable = 1'b0;
  logic        pin_wait;
  logic        cfg_ddr = 1'b0, cfg_clk_inv = 1'b0;
  logic [4:0]  cfg_width = 5'd16;
  logic        m_valid, m_ready = 1'b1, m_sol;
  logic [15:0] m_data;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [16:0] got_q[$], exp_q[$];

  always #10 sys_clk = ~sys_clk;

  ppr_rx uut (
    .sys_clk(sys_clk), .rst_n(rst_n), .io_clk(io_clk),
    .pin_data(pin_data), .pin_start(pin_start), .pin_enable(pin_enable),
    .pin_wait(pin_wait), .cfg_ddr(cfg_ddr), .cfg_clk_inv(cfg_clk_inv),
    .cfg_width(cfg_width), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_sol(m_sol)
  );

  // record the transfer that the next rising sys_clk edge performs
  always @(negedge sys_clk) if (rst_n && m_valid && m_ready) got_q.push_back({m_sol, m_data});

  typedef struct packed {
    logic ddr; logic inv; logic [4:0] w;
    logic ren; logic rsol; logic [15:0] rd;
    logic fen; logic fsol; logic [15:0] fd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,5'd16, 1'b1,1'b1,16'hA5C3, 1'b1,1'b0,16'h1111}, // R1 R5
    '{1'b0,1'b0,5'd16, 1'b1,1'b0,16'h0F0F, 1'b1,1'b1,16'h2222}, // R1
    '{1'b0,1'b0,5'd16, 1'b0,1'b1,16'h7777, 1'b1,1'b0,16'h8888}, // R4
    '{1'b0,1'b1,5'd16, 1'b1,1'b0,16'h3333, 1'b1,1'b1,16'hBEEF}, // R2
    '{1'b0,1'b1,5'd16, 1'b1,1'b0,16'h4444, 1'b0,1'b0,16'h5555}, // R2 R4
    '{1'b1,1'b0,5'd16, 1'b1,1'b1,16'h1234, 1'b1,1'b0,16'h5678}, // R3 R11
    '{1'b1,1'b1,5'd16, 1'b1,1'b0,16'hABCD, 1'b1,1'b1,16'h00FF}, // R3 inv ignored
    '{1'b1,1'b0,5'd16, 1'b0,1'b0,16'h6666, 1'b1,1'b0,16'h4321}, // R3 R4
    '{1'b1,1'b0,5'd16, 1'b1,1'b0,16'h9999, 1'b0,1'b1,16'hEEEE}, // R3 R4
    '{1'b0,1'b0,5'd8,  1'b1,1'b0,16'hFFFF, 1'b0,1'b0,16'h0000}, // R6
    '{1'b1,1'b0,5'd12, 1'b1,1'b1,16'hF0F0, 1'b1,1'b0,16'h8765}, // R6 R3
    '{1'b0,1'b0,5'd3,  1'b1,1'b0,16'h1234, 1'b0,1'b0,16'h0000}, // R6 clamp low
    '{1'b0,1'b0,5'd20, 1'b1,1'b0,16'hCAFE, 1'b0,1'b0,16'h0000}  // R6 clamp high
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] bmask(input int w);
    int e;
    e = (w < 8) ? 8 : ((w > 16) ? 16 : w);
    return 16'((32'h1 << e) - 1);
  endfunction

  task automatic io_cycle(input logic ren, input logic rsol, input logic [15:0] rd,
                          input logic fen, input logic fsol, input logic [15:0] fd);
    pin_enable = ren; pin_start = rsol; pin_data = rd;
    #50 io_clk = 1'b1;
    #50 pin_enable = fen; pin_start = fsol; pin_data = fd;
    #50 io_clk = 1'b0;
    #50;
  endtask

  task automatic io_idle(input int n);
    for (int i = 0; i < n; i++) io_cycle(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic set_ready(input logic v);
    @(posedge sys_clk); #5 m_ready = v;
  endtask

  task automatic compare(input string tag);
    chk(got_q.size() == exp_q.size(), "R4", {tag, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      chk(got_q[i][15:0] == exp_q[i][15:0], {tag, "/R11"}, "word data",
          32'(got_q[i][15:0]), 32'(exp_q[i][15:0]));
      chk(got_q[i][16] == exp_q[i][16], "R5", "start-of-line flag",
          32'(got_q[i][16]), 32'(exp_q[i][16]));
    end
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t v;
    string tag;
    #95 rst_n = 1'b1;
    repeat (3) @(posedge sys_clk);
    @(negedge sys_clk);
    chk(m_valid == 1'b0, "R10", "m_valid after reset", m_valid, 0);
    chk(pin_wait == 1'b0, "R10", "pin_wait after reset", pin_wait, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      cfg_ddr = v.ddr; cfg_clk_inv = v.inv; cfg_width = v.w;
      io_cycle(v.ren, v.rsol, v.rd, v.fen, v.fsol, v.fd);
      io_idle(2);
      repeat (20) @(posedge sys_clk);
      tag = v.ddr ? "R3" : (v.inv ? "R2" : "R1");
      if (v.w != 5'd16) tag = {tag, "/R6"};
      if (v.ddr) begin
        if (v.ren) exp_q.push_back({v.rsol, v.rd & bmask(int'(v.w))});
        if (v.fen) exp_q.push_back({v.fsol, v.fd & bmask(int'(v.w))});
      end else if (v.inv) begin
        if (v.fen) exp_q.push_back({v.fsol, v.fd & bmask(int'(v.w))});
      end else begin
        if (v.ren) exp_q.push_back({v.rsol, v.rd & bmask(int'(v.w))});
      end
      compare(tag);
    end

    // R7: stalled output holds its word
    cfg_ddr = 1'b1; cfg_clk_inv = 1'b0; cfg_width = 5'd16;
    set_ready(1'b0);
    io_cycle(1'b1, 1'b1, 16'hC001, 1'b1, 1'b0, 16'hC002);
    io_idle(2);
    repeat (20) @(posedge sys_clk);
    @(negedge sys_clk);
    chk(m_valid == 1'b1, "R7", "valid while stalled", m_valid, 1);
    chk(m_data == 16'hC001, "R7", "data while stalled", m_data, 16'hC001);
    repeat (5) @(negedge sys_clk);
    chk(m_valid == 1'b1 && m_data == 16'hC001 && m_sol == 1'b1, "R7", "held word",
        {m_valid, m_sol, m_data}, {2'b11, 16'hC001});
    set_ready(1'b1);
    repeat (10) @(posedge sys_clk);
    exp_q.push_back({1'b1, 16'hC001});
    exp_q.push_back({1'b0, 16'hC002});
    compare("R7");

    // R8 / R9: fill the FIFO with the stream stalled
    cfg_ddr = 1'b0; cfg_clk_inv = 1'b0;
    set_ready(1'b0);
    for (int i = 1; i <= 5; i++) io_cycle(1'b1, 1'b0, 16'h0100 + 16'(i), 1'b0, 1'b0, 16'h0);
    io_idle(2);
    chk(pin_wait == 1'b0, "R8", "wait with 3 free entries", pin_wait, 0);
    io_cycle(1'b1, 1'b0, 16'h0106, 1'b0, 1'b0, 16'h0);
    io_idle(2);
    chk(pin_wait == 1'b1, "R8", "wait with 2 free entries", pin_wait, 1);
    for (int i = 7; i <= 10; i++) io_cycle(1'b1, 1'b0, 16'h0100 + 16'(i), 1'b0, 1'b0, 16'h0);
    io_idle(2);
    chk(pin_wait == 1'b1, "R8", "wait when full", pin_wait, 1);
    set_ready(1'b1);
    repeat (40) @(posedge sys_clk);
    for (int i = 1; i <= 8; i++) exp_q.push_back({1'b0, 16'h0100 + 16'(i)});
    compare("R9");
    io_idle(4);
    chk(pin_wait == 1'b0, "R8", "wait released after drain", pin_wait, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule